// File: doc/BRIEF.md
# Per-CPU Performance Level Controller

This block gives every virtual CPU its own small window of 32-bit registers on a plain read/write bus. Through its window, software reads the level the CPU runs at now and asks for a new one. It can also walk the list of supported levels through an indirect port: it selects an index, then reads the entry. Finally it can read the number of the performance domain the CPU sits in. Levels carry no unit. They are scaled so that the strongest level of any CPU is 1024.

Each CPU is built either with a discrete level list or in continuous mode. A list length of one selects continuous mode, and the single entry is then the ceiling. A request is rounded or clamped to a legal level. The result goes to the writing CPU and to every CPU that reports the same domain number, in the same clock edge. The level each CPU holds is driven out on a port for the power logic to act on. Tables, lengths and domains are fixed at elaboration by parameters.

Top module: `perf_level_ctrl`

## Requirements
- R1: The address splits into 32-byte windows. Bits [ADDR_W-1:5] pick the CPU and bits [4:0] pick the register. Offsets are 0x00 current level (read), 0x04 level request (write), 0x08 list length (read), 0x0C entry index (write), 0x10 entry value (read) and 0x14 domain number (read). Read data is registered and appears the cycle after `bus_rd`.
- R2: After reset, every CPU's current level equals the top entry of its own list, and every entry index is zero.
- R3: In continuous mode (list length 1), a request from 1 to the ceiling is taken as written. A request above the ceiling is clamped to the ceiling. A request of 0 changes nothing.
- R4: In list mode (length above 1), a request takes the smallest list entry that is at least the request. If no entry is that large, it takes the largest entry. A request of 0 therefore gives the smallest entry.
- R5: An accepted request shows in the current-level register and on `lvl_out` after the clock edge that samples the write, and not before. CPU c occupies `lvl_out[c*LVL_W +: LVL_W]`.
- R6: An accepted request sets every CPU with the writer's domain number to the same level in the same edge. CPUs in other domains keep their levels.
- R7: Reading 0x10 returns the list entry at the stored index. It returns 0 when the index is at or beyond the list length. In continuous mode, entry 0 reads as the ceiling.
- R8: Offsets 0x08 and 0x14 return the CPU's list length and domain number.
- R9: Offsets other than the six above, including the write-only 0x04 and 0x0C, read as 0. Addresses past the last CPU window read as 0, and writes to them change nothing.
- R10: Writes to 0x00, 0x08, 0x10 and 0x14 change no state.
- R11: For a list of length L with ceiling M, entry j is (M/L)*(j+1) using integer division when j < L-1, and M when j = L-1. The default build has four CPUs:
  - CPU 0: length 16, ceiling 1024, domain 0.
  - CPU 1: length 16, ceiling 1024, domain 0.
  - CPU 2: length 7, ceiling 425, domain 1.
  - CPU 3: length 1, ceiling 512, domain 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lvl_out | output | N_CPU*LVL_W | Current level of every CPU, CPU 0 in the low bits |

## Verification
The bench goes after the rounding edges: a request exactly on a list entry, one just above an entry, one above the top entry, and a zero. A design with an off-by-one comparison would step to the wrong neighbour, and one that searched the list from the top would pick the largest entry instead of the nearest. It also writes to the CPUs that share a domain and then reads both, which catches a bank that updates only the writer. Reading an index at or past the list end catches a port that returns stale or out-of-list values. Writes to read-only offsets and to windows past the last CPU catch decoding that aliases onto a live register.

// File: rtl/vpl_pkg.sv
package vpl_pkg;

  localparam int REG_W = 32;

  localparam logic [4:0] OFF_CUR = 5'h00;
  localparam logic [4:0] OFF_REQ = 5'h04;
  localparam logic [4:0] OFF_LEN = 5'h08;
  localparam logic [4:0] OFF_SEL = 5'h0C;
  localparam logic [4:0] OFF_ENT = 5'h10;
  localparam logic [4:0] OFF_DOM = 5'h14;

  // Level list entry: evenly spaced steps, the last one pinned to the ceiling.
  function automatic logic [31:0] entry_value(input logic [31:0] idx,
                                              input int unsigned len,
                                              input int unsigned ceil_lvl);
    logic [31:0] step;
    if (len == 0 || idx >= len) return 32'd0;
    if (idx == len - 1) return 32'(ceil_lvl);
    step = 32'(ceil_lvl / len);
    return step * (idx + 32'd1);
  endfunction

endpackage

// File: rtl/vpl_quant.sv
module vpl_quant #(
  parameter int MAX_ENT = 16,
  parameter int LVL_W   = 16,
  parameter int TBL_LEN = 1,
  parameter int TBL_MAX = 1024
) (
  input  logic [31:0]      req,
  output logic             ok,
  output logic [LVL_W-1:0] lvl
);
  import vpl_pkg::*;

  localparam logic [31:0] TOP = 32'(TBL_MAX);

  generate
    if (TBL_LEN <= 1) begin : g_cont
      always_comb begin
        ok = (req != 32'd0);
        if (req > TOP) lvl = LVL_W'(TOP);
        else           lvl = req[LVL_W-1:0];
      end
    end else begin : g_tbl
      always_comb begin
        logic [31:0] ent;
        ok  = 1'b1;
        lvl = LVL_W'(TOP);
        // walk downward so the smallest qualifying entry is the last assignment
        for (int j = MAX_ENT - 1; j >= 0; j--) begin
          ent = entry_value(32'(j), TBL_LEN, TBL_MAX);
          if (j < TBL_LEN && ent >= req) lvl = ent[LVL_W-1:0];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vpl_level_bank.sv
module vpl_level_bank #(
  parameter int N_CPU  = 4,
  parameter int LVL_W  = 16,
  parameter int CIDX_W = 2,
  parameter logic [N_CPU*16-1:0] CPU_MAX = '0,
  parameter logic [N_CPU*8-1:0]  CPU_DOM = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   apply,
  input  logic [CIDX_W-1:0]      src,
  input  logic [N_CPU-1:0]       q_ok,
  input  logic [N_CPU*LVL_W-1:0] q_lvl,
  output logic [N_CPU*LVL_W-1:0] cur_flat
);

  logic [LVL_W-1:0] cur [N_CPU];
  logic [LVL_W-1:0] new_lvl;
  logic             new_ok;
  logic [7:0]       src_dom;

  always_comb begin
    new_lvl = q_lvl[src*LVL_W +: LVL_W];
    new_ok  = q_ok[src];
    src_dom = CPU_DOM[src*8 +: 8];
  end

  generate
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      localparam logic [7:0]  MY_DOM = CPU_DOM[c*8 +: 8];
      localparam logic [15:0] MY_MAX = CPU_MAX[c*16 +: 16];

      always_ff @(posedge clk) begin
        if (rst)
          cur[c] <= LVL_W'(MY_MAX);
        else if (apply && new_ok && src_dom == MY_DOM)
          cur[c] <= new_lvl;
      end

      assign cur_flat[c*LVL_W +: LVL_W] = cur[c];

      AST_LEVEL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (cur[c] != '0) && (32'(cur[c]) <= 32'(MY_MAX))); // R3

      for (genvar d = c + 1; d < N_CPU; d++) begin : g_pair
        if (CPU_DOM[d*8 +: 8] == MY_DOM) begin : g_same
          AST_DOMAIN_SHARED: assert property (@(posedge clk) disable iff (rst)
            cur[c] == cur[d]); // R6
        end
      end
    end
  endgenerate

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !(apply && new_ok) |=> $stable(cur_flat)); // R10

endmodule

// File: rtl/vpl_read_port.sv
module vpl_read_port #(
  parameter int N_CPU   = 4,
  parameter int MAX_ENT = 16,
  parameter int LVL_W   = 16,
  parameter int CIDX_W  = 2,
  parameter logic [N_CPU*8-1:0]  CPU_LEN = '0,
  parameter logic [N_CPU*16-1:0] CPU_MAX = '0,
  parameter logic [N_CPU*8-1:0]  CPU_DOM = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd,
  input  logic                   hit,
  input  logic [CIDX_W-1:0]      cpu,
  input  logic [4:0]             off,
  input  logic                   sel_wr,
  input  logic [31:0]            wdata,
  input  logic [N_CPU*LVL_W-1:0] cur_flat,
  output logic [31:0]            rdata
);
  import vpl_pkg::*;

  logic [31:0] sel  [N_CPU];
  logic [31:0] ent  [N_CPU];
  logic [31:0] lens [N_CPU];
  logic [31:0] rd_mux;

  generate
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      localparam int MY_LEN = int'(CPU_LEN[c*8 +: 8]);
      localparam int MY_MAX = int'(CPU_MAX[c*16 +: 16]);

      always_ff @(posedge clk) begin
        if (rst)
          sel[c] <= '0;
        else if (sel_wr && cpu == CIDX_W'(c))
          sel[c] <= wdata;
      end

      assign ent[c]  = entry_value(sel[c], MY_LEN, MY_MAX);
      assign lens[c] = 32'(MY_LEN);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_CUR: rd_mux = 32'(cur_flat[cpu*LVL_W +: LVL_W]);
        OFF_LEN: rd_mux = lens[cpu];
        OFF_ENT: rd_mux = ent[cpu];
        OFF_DOM: rd_mux = 32'(CPU_DOM[cpu*8 +: 8]);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd && !hit |=> rdata == 32'd0); // R9

  AST_ENTRY_PAST_END: assert property (@(posedge clk) disable iff (rst)
    rd && hit && off == OFF_ENT && sel[cpu] >= lens[cpu] |=> rdata == 32'd0); // R7

endmodule

// File: rtl/perf_level_ctrl.sv
module perf_level_ctrl #(
  parameter int N_CPU   = 4,
  parameter int MAX_ENT = 16,
  parameter int LVL_W   = 16,
  parameter int ADDR_W  = 8,
  parameter logic [N_CPU*8-1:0]  CPU_LEN = {8'd1, 8'd7, 8'd16, 8'd16},
  parameter logic [N_CPU*16-1:0] CPU_MAX = {16'd512, 16'd425, 16'd1024, 16'd1024},
  parameter logic [N_CPU*8-1:0]  CPU_DOM = {8'd2, 8'd1, 8'd0, 8'd0}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [N_CPU*LVL_W-1:0] lvl_out
);
  import vpl_pkg::*;

  localparam int CIDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;
  localparam int WIN_W  = ADDR_W - 5;

  logic [WIN_W-1:0]  win;
  logic [4:0]        off;
  logic              hit;
  logic [CIDX_W-1:0] cpu;
  logic              req_wr, sel_wr;
  logic [N_CPU-1:0]  q_ok;
  logic [N_CPU*LVL_W-1:0] q_lvl;

  assign win    = bus_addr[ADDR_W-1:5];
  assign off    = bus_addr[4:0];
  assign hit    = int'(win) < N_CPU;
  assign cpu    = hit ? win[CIDX_W-1:0] : '0;
  assign req_wr = bus_wr && hit && off == OFF_REQ;
  assign sel_wr = bus_wr && hit && off == OFF_SEL;

  generate
    for (genvar c = 0; c < N_CPU; c++) begin : g_q
      vpl_quant #(
        .MAX_ENT (MAX_ENT),
        .LVL_W   (LVL_W),
        .TBL_LEN (int'(CPU_LEN[c*8 +: 8])),
        .TBL_MAX (int'(CPU_MAX[c*16 +: 16]))
      ) u_quant (
        .req (bus_wdata),
        .ok  (q_ok[c]),
        .lvl (q_lvl[c*LVL_W +: LVL_W])
      );
    end
  endgenerate

  vpl_level_bank #(
    .N_CPU   (N_CPU),
    .LVL_W   (LVL_W),
    .CIDX_W  (CIDX_W),
    .CPU_MAX (CPU_MAX),
    .CPU_DOM (CPU_DOM)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .apply    (req_wr),
    .src      (cpu),
    .q_ok     (q_ok),
    .q_lvl    (q_lvl),
    .cur_flat (lvl_out)
  );

  vpl_read_port #(
    .N_CPU   (N_CPU),
    .MAX_ENT (MAX_ENT),
    .LVL_W   (LVL_W),
    .CIDX_W  (CIDX_W),
    .CPU_LEN (CPU_LEN),
    .CPU_MAX (CPU_MAX),
    .CPU_DOM (CPU_DOM)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .hit      (hit),
    .cpu      (cpu),
    .off      (off),
    .sel_wr   (sel_wr),
    .wdata    (bus_wdata),
    .cur_flat (lvl_out),
    .rdata    (bus_rdata)
  );

  AST_WRITE_TAKES_EFFECT: assert property (@(posedge clk) disable iff (rst)
    req_wr && bus_wdata != 32'd0 |=> lvl_out[$past(cpu)*LVL_W +: LVL_W] != '0); // R5

endmodule

// File: tb/perf_level_ctrl_test.sv
module perf_level_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int LW = 16;

  int b_len [NC] = '{16, 16, 7, 1};
  int b_max [NC] = '{1024, 1024, 425, 512};
  int b_dom [NC] = '{0, 0, 1, 2};

  logic clk = 0;
  logic rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC*LW-1:0] lvl_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_cur [NC];
  logic [31:0] m_sel [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_level_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lvl_out(lvl_out));

  function automatic int b_entry(int c, logic [31:0] j);
    if (j >= 32'(b_len[c])) return 0;
    if (j == 32'(b_len[c] - 1)) return b_max[c];
    return (b_max[c] / b_len[c]) * (int'(j) + 1);
  endfunction

  function automatic int b_quant(int c, logic [31:0] d, output bit ok);
    ok = 1;
    if (b_len[c] == 1) begin
      if (d == 0) begin ok = 0; return 0; end
      return (d > 32'(b_max[c])) ? b_max[c] : int'(d);
    end
    for (int j = 0; j < b_len[c]; j++)
      if (32'(b_entry(c, 32'(j))) >= d) return b_entry(c, 32'(j));
    return b_max[c];
  endfunction

  function automatic logic [31:0] b_read(logic [7:0] a);
    int c = int'(a >> 5);
    logic [4:0] o = a[4:0];
    if (c >= NC) return 0;
    case (o)
      5'h00: return 32'(m_cur[c]);
      5'h08: return 32'(b_len[c]);
      5'h10: return 32'(b_entry(c, m_sel[c]));
      5'h14: return 32'(b_dom[c]);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_levels(string tag);
    for (int c = 0; c < NC; c++)
      check(tag, 32'(lvl_out[c*LW +: LW]), 32'(m_cur[c]));
  endtask

  task automatic m_write(logic [7:0] a, logic [31:0] d);
    int c = int'(a >> 5);
    bit ok;
    int lv;
    if (c >= NC) return;
    if (a[4:0] == 5'h04) begin
      lv = b_quant(c, d, ok);
      if (ok) for (int k = 0; k < NC; k++) if (b_dom[k] == b_dom[c]) m_cur[k] = lv;
    end else if (a[4:0] == 5'h0C) m_sel[c] = d;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    m_write(a, d);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(tag, bus_rdata, b_read(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240507));
    for (int c = 0; c < NC; c++) begin m_cur[c] = b_max[c]; m_sel[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;

    // R2 reset state
    check_levels("R2 reset levels");
    for (int c = 0; c < NC; c++) begin
      rd(8'(c*32 + 'h00), "R2 reset current");
      rd(8'(c*32 + 'h10), "R2 reset index zero");
      rd(8'(c*32 + 'h08), "R8 length");
      rd(8'(c*32 + 'h14), "R8 domain");
    end

    // R7/R11 indirect list reads
    wr(8'h0C, 15); rd(8'h10, "R7 top entry");
    wr(8'h0C, 16); rd(8'h10, "R7 index at length");
    wr(8'h0C, 32'hFFFF_FFF0); rd(8'h10, "R7 huge index");
    wr(8'h4C, 5);  rd(8'h50, "R11 stepped entry");
    wr(8'h4C, 6);  rd(8'h50, "R11 last entry");
    wr(8'h6C, 0);  rd(8'h70, "R7 continuous entry0");
    wr(8'h6C, 1);  rd(8'h70, "R7 continuous past end");

    // R5 timing: unchanged before the edge, new after it
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h04; bus_wdata = 100;
    #1 check("R5 before edge", 32'(lvl_out[0 +: LW]), 32'(m_cur[0]));
    @(negedge clk);
    bus_wr = 0;
    m_write(8'h04, 100);
    check("R5 after edge", 32'(lvl_out[0 +: LW]), 32'd128);
    check("R6 domain peer", 32'(lvl_out[LW +: LW]), 32'd128);
    check_levels("R6 other domains kept");

    // R4 list rounding
    wr(8'h24, 2000); rd(8'h00, "R4 above top"); rd(8'h20, "R4 above top writer");
    wr(8'h04, 0);    rd(8'h20, "R4 zero gives smallest");
    wr(8'h44, 361);  rd(8'h40, "R4 just above entry");
    wr(8'h44, 360);  rd(8'h40, "R4 exact entry");
    wr(8'h44, 1);    rd(8'h40, "R4 low request");
    check_levels("R4 levels");

    // R3 continuous mode
    wr(8'h64, 300);  rd(8'h60, "R3 in range");
    wr(8'h64, 0);    rd(8'h60, "R3 zero ignored");
    wr(8'h64, 9999); rd(8'h60, "R3 clamp");
    wr(8'h64, 1);    rd(8'h60, "R3 minimum");
    check_levels("R3 levels");

    // R10 read-only writes
    wr(8'h00, 7); wr(8'h08, 7); wr(8'h10, 7); wr(8'h14, 7);
    rd(8'h00, "R10 current kept"); rd(8'h08, "R10 length kept");
    rd(8'h10, "R10 entry kept");   rd(8'h14, "R10 domain kept");
    check_levels("R10 levels");

    // R9 unmapped
    rd(8'h18, "R9 offset 0x18"); rd(8'h04, "R9 request reads zero");
    rd(8'h0C, "R9 index reads zero"); rd(8'h02, "R9 unaligned");
    rd(8'h80, "R9 past last window");
    wr(8'h84, 64); wr(8'hA4, 1);
    check_levels("R9 write past windows");

    // R1 random mix over all windows
    for (int i = 0; i < 600; i++) begin
      int kind = int'($urandom % 4);
      int c = int'($urandom % 6);
      logic [4:0] o;
      case ($urandom % 8)
        0: o = 5'h00; 1: o = 5'h04; 2: o = 5'h08; 3: o = 5'h0C;
        4: o = 5'h10; 5: o = 5'h14; 6: o = 5'h18; default: o = 5'h1C;
      endcase
      case (kind)
        0: wr(8'(c*32 + 'h04), $urandom % 1200);
        1: wr(8'(c*32 + 'h0C), $urandom % 20);
        2: rd(8'(c*32) | 8'(o), "R1 random read");
        default: wr(8'(c*32) | 8'(o), $urandom);
      endcase
      check_levels("R1 random levels");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule